// File: doc/BRIEF.md
# Extended Target Address Calculator

This block forms the effective target address of a memory-reference instruction on a 24-bit machine with a 1 MiB byte-addressed memory. It also reports how the execute stage should treat that address. Six instruction flag bits choose the address form and the operand use. The flags are indirect (n), immediate (i), index (x), base (b), PC-relative (p) and extended (e). The address is formed from a 12-bit displacement, a 20-bit extended field, the next-instruction PC, the base register or a 15-bit legacy absolute field. The index register can then be added. Every sum wraps modulo 2^20.

The operand-use code tells the execute stage one of three things. The address may itself be the operand value. It may point at a word that holds the operand address. Or it may be the operand address. Fetching that word and reading the operand are done elsewhere. Encodings that cannot be honoured raise an illegal flag, and the address is then forced to zero. All outputs are registered and appear one clock after the inputs are sampled.

Top module: `xaddr_calc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the registered outputs become `tgt_addr` = 0, `use_mode` = 0 and `bad_combo` = 0.
- R2: The outputs after rising edge k depend only on the inputs sampled at edge k. Changing the inputs between edges leaves the outputs unchanged.
- R3: With n or i set, e=0, b=0 and p=0, the address is `fld[11:0]` zero-extended (direct, 0..4095). Bits `fld[19:12]` are ignored.
- R4: With n or i set, e=0, b=1 and p=0, the address is the low 20 bits of `base_reg` plus the zero-extended `fld[11:0]`.
- R5: With n or i set, e=0, b=0 and p=1, the address is `next_pc` plus `fld[11:0]` sign-extended in two's complement.
- R6: With n or i set, e=1, b=0 and p=0, the address is `fld[19:0]`.
- R7: When x=1, the low 20 bits of `index_reg` are added to the formed address. All sums wrap modulo 2^20.
- R8: `use_mode` is 1 (immediate) for i=1,n=0. It is 2 (indirect) for n=1,i=0. It is 0 (simple) for n=i=1 and for n=i=0.
- R9: With n=i=0 (legacy encoding), the address is the 15-bit value {b, p, e, `fld[11:0]`}, with b at bit 14, p at bit 13 and e at bit 12. It is zero-extended, `fld[19:12]` is ignored, and b, p and e never make the encoding illegal.
- R10: `bad_combo` is 1 when x=1 with exactly one of n, i set. Outside legacy encoding it is also 1 when b=p=1, or when e=1 with b or p set. When `bad_combo` is 1, `tgt_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ind_bit | input | 1 | Flag n |
| imm_bit | input | 1 | Flag i |
| idx_bit | input | 1 | Flag x |
| base_bit | input | 1 | Flag b |
| pcrel_bit | input | 1 | Flag p |
| ext_bit | input | 1 | Flag e |
| fld | input | 20 | Displacement in [11:0], or the full extended address |
| next_pc | input | 20 | Address of the following instruction |
| base_reg | input | 24 | Base register contents |
| index_reg | input | 24 | Index register contents |
| tgt_addr | output | 20 | Registered target address |
| use_mode | output | 2 | 0 simple, 1 immediate, 2 indirect |
| bad_combo | output | 1 | Illegal flag combination |

## Verification
The assertions take for granted that the flags and fields are known, 0 or 1 values at every edge where reset is high. They also take for granted that a property about outputs refers to inputs held across the preceding edge. The stimulus meets both conditions by driving every input on the falling edge from fully defined random values. Random flag vectors are drawn uniformly, so legal forms, legacy forms and every illegal combination all appear. Directed vectors add the wrap-around sums, the negative PC-relative displacement and legacy fields with stray upper bits.

// File: rtl/xaddr_pkg.sv
package xaddr_pkg;

    typedef enum logic [1:0] {
        USE_SIMPLE = 2'd0,
        USE_IMM    = 2'd1,
        USE_IND    = 2'd2
    } use_e;

    typedef struct packed {
        logic n;
        logic i;
        logic x;
        logic b;
        logic p;
        logic e;
    } flags_t;

endpackage

// File: rtl/xaddr_form.sv
module xaddr_form
    import xaddr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 24,
    parameter int DISP_W = 12
) (
    input  flags_t              fl,
    input  logic [ADDR_W-1:0]   fld,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [WORD_W-1:0]   base,
    input  logic [WORD_W-1:0]   idx,
    output logic [ADDR_W-1:0]   addr
);
    localparam int LEG_W = DISP_W + 3;
    localparam int PAD_W = ADDR_W - DISP_W;
    localparam int LPAD_W = ADDR_W - LEG_W;

    logic [DISP_W-1:0] disp;
    logic [ADDR_W-1:0] disp_z;
    logic [ADDR_W-1:0] disp_s;
    logic [ADDR_W-1:0] legacy_a;
    logic [ADDR_W-1:0] pre_a;
    logic              legacy;

    assign disp     = fld[DISP_W-1:0];
    assign disp_z   = {{PAD_W{1'b0}}, disp};
    assign disp_s   = {{PAD_W{disp[DISP_W-1]}}, disp};
    assign legacy_a = {{LPAD_W{1'b0}}, fl.b, fl.p, fl.e, disp};
    assign legacy   = !fl.n && !fl.i;

    always_comb begin
        if (legacy) begin
            pre_a = legacy_a;
        end else if (fl.e) begin
            pre_a = fld;
        end else if (fl.b && !fl.p) begin
            pre_a = base[ADDR_W-1:0] + disp_z;
        end else if (fl.p && !fl.b) begin
            pre_a = pc + disp_s;
        end else begin
            pre_a = disp_z;
        end
    end

    assign addr = fl.x ? (pre_a + idx[ADDR_W-1:0]) : pre_a;

endmodule

// File: rtl/xaddr_use_dec.sv
module xaddr_use_dec
    import xaddr_pkg::*;
(
    input  flags_t fl,
    output use_e   mode,
    output logic   bad
);
    logic legacy;
    logic idx_bad;
    logic fmt_bad;

    assign legacy  = !fl.n && !fl.i;
    assign idx_bad = fl.x && (fl.n ^ fl.i);
    assign fmt_bad = !legacy && ((fl.b && fl.p) || (fl.e && (fl.b || fl.p)));
    assign bad     = idx_bad || fmt_bad;

    always_comb begin
        unique case ({fl.n, fl.i})
            2'b01:   mode = USE_IMM;
            2'b10:   mode = USE_IND;
            default: mode = USE_SIMPLE;
        endcase
    end

endmodule

// File: rtl/xaddr_calc.sv
module xaddr_calc
    import xaddr_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 24,
    parameter int DISP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ind_bit,
    input  logic              imm_bit,
    input  logic              idx_bit,
    input  logic              base_bit,
    input  logic              pcrel_bit,
    input  logic              ext_bit,
    input  logic [ADDR_W-1:0] fld,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [WORD_W-1:0] base_reg,
    input  logic [WORD_W-1:0] index_reg,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [1:0]        use_mode,
    output logic              bad_combo
);
    typedef struct packed {
        logic [ADDR_W-1:0] tgt;
        use_e              mode;
        logic              bad;
    } out_t;

    flags_t            fl;
    logic [ADDR_W-1:0] formed;
    use_e              dec_mode;
    logic              dec_bad;
    out_t              st_d;
    out_t              st_q;

    assign fl = '{n: ind_bit, i: imm_bit, x: idx_bit,
                  b: base_bit, p: pcrel_bit, e: ext_bit};

    xaddr_form #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DISP_W (DISP_W)
    ) u_form (
        .fl   (fl),
        .fld  (fld),
        .pc   (next_pc),
        .base (base_reg),
        .idx  (index_reg),
        .addr (formed)
    );

    xaddr_use_dec u_dec (
        .fl   (fl),
        .mode (dec_mode),
        .bad  (dec_bad)
    );

    always_comb begin
        st_d      = st_q;
        st_d.bad  = dec_bad;
        st_d.mode = dec_mode;
        st_d.tgt  = dec_bad ? '0 : formed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{tgt: '0, mode: USE_SIMPLE, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt_addr  = st_q.tgt;
    assign use_mode  = st_q.mode;
    assign bad_combo = st_q.bad;

endmodule

// File: rtl/xaddr_chk.sv
module xaddr_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ind_bit,
    input logic              imm_bit,
    input logic              idx_bit,
    input logic              base_bit,
    input logic              pcrel_bit,
    input logic              ext_bit,
    input logic [ADDR_W-1:0] fld,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [1:0]        use_mode,
    input logic              bad_combo
);
    logic armed_q = 1'b0;

    always_ff @(posedge clk) armed_q <= 1'b1;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        armed_q && $past(!rst_n) |-> (tgt_addr == '0 && use_mode == 2'd0 && !bad_combo));

    // R8
    imm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(imm_bit && !ind_bit) |-> use_mode == 2'd1);

    // R8
    ind_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ind_bit && !imm_bit) |-> use_mode == 2'd2);

    // R10
    idx_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(idx_bit && (ind_bit ^ imm_bit)) |-> bad_combo);

    // R10
    bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_combo |-> tgt_addr == '0);

    // R6
    ext_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ext_bit && ind_bit && imm_bit && !base_bit && !pcrel_bit && !idx_bit)
        |-> (tgt_addr == $past(fld) && !bad_combo));

endmodule

bind xaddr_calc xaddr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ind_bit   (ind_bit),
    .imm_bit   (imm_bit),
    .idx_bit   (idx_bit),
    .base_bit  (base_bit),
    .pcrel_bit (pcrel_bit),
    .ext_bit   (ext_bit),
    .fld       (fld),
    .tgt_addr  (tgt_addr),
    .use_mode  (use_mode),
    .bad_combo (bad_combo)
);

// File: tb/tb_xaddr_calc.sv
`timescale 1ns/1ps
module tb_xaddr_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        n_b = 1'b0, i_b = 1'b0, x_b = 1'b0, b_b = 1'b0, p_b = 1'b0, e_b = 1'b0;
    logic [19:0] fld = '0, pc = '0;
    logic [23:0] breg = '0, xreg = '0;
    logic [19:0] tgt;
    logic [1:0]  mode;
    logic        bad;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    xaddr_calc dut (
        .clk(clk), .rst_n(rst_n),
        .ind_bit(n_b), .imm_bit(i_b), .idx_bit(x_b),
        .base_bit(b_b), .pcrel_bit(p_b), .ext_bit(e_b),
        .fld(fld), .next_pc(pc), .base_reg(breg), .index_reg(xreg),
        .tgt_addr(tgt), .use_mode(mode), .bad_combo(bad)
    );

    function automatic logic [22:0] model(logic n, logic i, logic x, logic b, logic p, logic e,
                                          logic [19:0] f, logic [19:0] npc,
                                          logic [23:0] bb, logic [23:0] xx);
        logic [19:0] a;
        logic [1:0]  m;
        logic        lg, bd;
        lg = !n && !i;
        m  = (i && !n) ? 2'd1 : ((n && !i) ? 2'd2 : 2'd0);
        bd = (x && (n != i)) || (!lg && ((b && p) || (e && (b || p))));
        if (lg)              a = {5'd0, b, p, e, f[11:0]};
        else if (e)          a = f;
        else if (b && !p)    a = bb[19:0] + {8'd0, f[11:0]};
        else if (p && !b)    a = npc + {{8{f[11]}}, f[11:0]};
        else                 a = {8'd0, f[11:0]};
        if (x) a = a + xx[19:0];
        if (bd) a = '0;
        return {bd, m, a};
    endfunction

    task automatic check(string req, logic [22:0] got, logic [22:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got bad=%0b mode=%0d addr=%05h expected bad=%0b mode=%0d addr=%05h",
                     req, got[22], got[21:20], got[19:0], exp[22], exp[21:20], exp[19:0]);
        end
    endtask

    task automatic drive(logic [5:0] fl, logic [19:0] f, logic [19:0] npc,
                         logic [23:0] bb, logic [23:0] xx);
        {n_b, i_b, x_b, b_b, p_b, e_b} = fl;
        fld = f; pc = npc; breg = bb; xreg = xx;
    endtask

    // flag order in fl: {n,i,x,b,p,e}
    task automatic run(string req, logic [5:0] fl, logic [19:0] f, logic [19:0] npc,
                       logic [23:0] bb, logic [23:0] xx);
        @(negedge clk);
        drive(fl, f, npc, bb, xx);
        @(posedge clk);
        @(negedge clk);
        check(req, {bad, mode, tgt},
              model(fl[5], fl[4], fl[3], fl[2], fl[1], fl[0], f, npc, bb, xx));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int unused_seed;
        logic [22:0] held;
        unused_seed = $urandom(32'd1234);
        // R1: reset with busy inputs
        drive(6'b011010, 20'hABCDE, 20'h12345, 24'h00FFFF, 24'h000777);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {bad, mode, tgt}, 23'd0);
        rst_n = 1'b1;

        run("R3 direct",         6'b110000, 20'hFF123, 20'h00000, 24'h0, 24'h0);
        run("R4 base rel",       6'b110100, 20'h00003, 20'h00000, 24'h000033, 24'h0);
        run("R5 pc rel neg",     6'b110010, 20'h00FFF, 20'h00010, 24'h0, 24'h0);
        run("R5 pc rel wrap",    6'b110010, 20'h00800, 20'h00100, 24'h0, 24'h0);
        run("R6 long",           6'b110001, 20'hFEDCB, 20'h11111, 24'h0, 24'h0);
        run("R7 index wrap",     6'b111001, 20'hFFFF0, 20'h0, 24'h0, 24'hFF0020);
        run("R7 base idx wrap",  6'b111100, 20'h00FFF, 20'h0, 24'h0FFFFF, 24'h000002);
        run("R8 immediate",      6'b010000, 20'h00042, 20'h0, 24'h0, 24'h0);
        run("R8 indirect",       6'b100010, 20'h00004, 20'h00200, 24'h0, 24'h0);
        run("R9 legacy",         6'b000101, 20'hAB123, 20'h0, 24'h0, 24'h0);
        run("R9 legacy idx",     6'b001111, 20'hFFFFF, 20'h0, 24'h0, 24'h000001);
        run("R10 imm idx",       6'b011000, 20'h00010, 20'h0, 24'h0, 24'h5);
        run("R10 ind idx",       6'b101000, 20'h00010, 20'h0, 24'h0, 24'h5);
        run("R10 b and p",       6'b110110, 20'h00010, 20'h0, 24'h100, 24'h0);
        run("R10 e with b",      6'b110101, 20'h00010, 20'h0, 24'h100, 24'h0);
        run("R10 e with p",      6'b010011, 20'h00010, 20'h0, 24'h100, 24'h0);

        // R2: input change between edges must not reach outputs
        @(negedge clk);
        held = {bad, mode, tgt};
        drive(6'b110001, 20'h0BEEF, 20'h0, 24'h0, 24'h0);
        #1;
        check("R2 hold before edge", {bad, mode, tgt}, held);
        @(posedge clk);
        @(negedge clk);
        check("R2 update after edge", {bad, mode, tgt},
              model(1, 1, 0, 0, 0, 1, 20'h0BEEF, 20'h0, 24'h0, 24'h0));

        for (int k = 0; k < 400; k++) begin
            logic [5:0] fl;
            fl = 6'($urandom);
            run("R3-R10 random", fl, 20'($urandom), 20'($urandom), 24'($urandom), 24'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule